// File: doc/BRIEF.md
# 625-Line Field and Vertical Blank Generator

This block tracks the line position inside a 625-line, 50 Hz interlaced frame. It produces, for every line, the field flag (F) and the vertical blanking flag (V) used in ITU-656 timing reference codes. A line-start strobe advances the count, and an optional resync strobe realigns the count to the top of the frame. The line number, F and V all come from registers, so downstream SAV/EAV insertion or gating logic sees values that hold still for a whole line.

The line number runs from 1 to 625. F is 0 in the first field and 1 in the second field. V marks the blanking lines around each field. All three outputs change only on the clock edge that samples a line-start strobe.

Top module: `fv625_gen`

## Requirements
- R1: While rst_ni is low, and until the first line-start strobe, line_o is 625, field_o is 1 and vblank_o is 1.
- R2: An edge that samples line_start_i high with no resync in effect sets line_o to its previous value plus one. line_o, field_o and vblank_o do not change on any edge that samples line_start_i low.
- R3: A line-start strobe taken while line_o is 625, with no resync in effect, sets line_o to 1.
- R4: Lines 1 to 22 have field_o=0 and vblank_o=1.
- R5: Lines 23 to 310 have field_o=0 and vblank_o=0.
- R6: Lines 311 and 312 have field_o=0 and vblank_o=1.
- R7: Lines 313 to 335 have field_o=1 and vblank_o=1.
- R8: Lines 336 to 623 have field_o=1 and vblank_o=0.
- R9: Lines 624 and 625 have field_o=1 and vblank_o=1.
- R10: A resync strobe sampled without a line-start strobe leaves all outputs unchanged. It is held pending, and the next line-start strobe loads line 1.
- R11: A resync strobe sampled in the same cycle as a line-start strobe loads line 1 at that strobe.
- R12: Several resync strobes before one line-start strobe act as a single resync. The pending resync is cleared once it is used, so the following strobe gives line 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| resync_i | input | 1 | Frame resync request, applied at the next line start |
| line_o | output | 10 | Current line number, 1 to 625 |
| field_o | output | 1 | Field flag F, 0 = first field, 1 = second field |
| vblank_o | output | 1 | Vertical blanking flag V |

## Verification
The bench runs more than two full frames of sparse strobes, with gaps of several cycles between them. This shows the flags holding between strobes and reaching every F/V boundary and the 625-to-1 wrap. A run of back-to-back strobes checks that advancing on consecutive cycles skips nothing. Resync is tried in three ways: alone in the middle of a field, coincident with a strobe, and repeated before one strobe. These patterns separate the pending path, the immediate path and the clearing of the pending state.

// File: rtl/fv625_pkg.sv
package fv625_pkg;
  typedef struct packed {
    logic field;
    logic vblank;
  } fv_t;
endpackage

// File: rtl/fv625_line_ctr.sv
module fv625_line_ctr #(
  parameter int LINES = 625,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic          resync_i,
  output logic [LW-1:0] line_d_o,
  output logic [LW-1:0] line_q_o
);
  localparam logic [LW-1:0] LAST = LW'(LINES);
  localparam logic [LW-1:0] FIRST = LW'(1);

  logic [LW-1:0] line_q;
  logic          pend_q;
  logic          reload;

  assign reload = resync_i | pend_q;

  always_comb begin
    if (!line_start_i)       line_d_o = line_q;
    else if (reload)         line_d_o = FIRST;
    else if (line_q == LAST) line_d_o = FIRST;
    else                     line_d_o = line_q + FIRST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LAST;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_d_o;
      // a strobe consumes any request; otherwise a request is held
      if (line_start_i)  pend_q <= 1'b0;
      else if (resync_i) pend_q <= 1'b1;
    end
  end

  assign line_q_o = line_q;

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && !reload && line_q != LAST |=> line_q == $past(line_q) + FIRST) else $error("step"); // R2
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && !reload && line_q == LAST |=> line_q == FIRST) else $error("wrap"); // R3
  AST_RESYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && pend_q |=> line_q == FIRST && !pend_q) else $error("resync"); // R10
  AST_RESYNC_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i && resync_i |=> line_q == FIRST) else $error("resync now"); // R11
  AST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q >= FIRST && line_q <= LAST) else $error("range"); // R3
endmodule

// File: rtl/fv625_decode.sv
module fv625_decode
  import fv625_pkg::*;
#(
  parameter int LINES        = 625,
  parameter int TOP_BLK_LAST = 22,
  parameter int MID_BLK_FRST = 311,
  parameter int FLD2_FRST    = 313,
  parameter int F2_BLK_LAST  = 335,
  parameter int END_BLK_FRST = 624,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic [LW-1:0] line_i,
  output fv_t           fv_o
);
  always_comb begin
    fv_o.field  = line_i >= LW'(FLD2_FRST);
    fv_o.vblank = (line_i <= LW'(TOP_BLK_LAST))
               || (line_i >= LW'(MID_BLK_FRST) && line_i <= LW'(F2_BLK_LAST))
               || (line_i >= LW'(END_BLK_FRST));
  end
endmodule

// File: rtl/fv625_gen.sv
module fv625_gen
  import fv625_pkg::*;
#(
  parameter int LINES        = 625,
  parameter int TOP_BLK_LAST = 22,
  parameter int MID_BLK_FRST = 311,
  parameter int FLD2_FRST    = 313,
  parameter int F2_BLK_LAST  = 335,
  parameter int END_BLK_FRST = 624,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic          resync_i,
  output logic [LW-1:0] line_o,
  output logic          field_o,
  output logic          vblank_o
);
  logic [LW-1:0] line_d;
  fv_t           fv_d, fv_q;

  fv625_line_ctr #(.LINES(LINES)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .resync_i(resync_i), .line_d_o(line_d), .line_q_o(line_o)
  );

  fv625_decode #(
    .LINES(LINES), .TOP_BLK_LAST(TOP_BLK_LAST), .MID_BLK_FRST(MID_BLK_FRST),
    .FLD2_FRST(FLD2_FRST), .F2_BLK_LAST(F2_BLK_LAST), .END_BLK_FRST(END_BLK_FRST)
  ) u_dec (.line_i(line_d), .fv_o(fv_d));

  // flags decoded from the next line so they land with the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fv_q <= '{field: 1'b1, vblank: 1'b1};
    else if (line_start_i) fv_q <= fv_d;
  end

  assign field_o  = fv_q.field;
  assign vblank_o = fv_q.vblank;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(line_o) && $stable(field_o) && $stable(vblank_o)) else $error("hold"); // R2
  AST_FIELD2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o >= LW'(FLD2_FRST) |-> field_o) else $error("field2"); // R8
  AST_FIELD1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o < LW'(FLD2_FRST) |-> !field_o) else $error("field1"); // R5
  AST_ACTIVE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o > LW'(TOP_BLK_LAST) && line_o < LW'(MID_BLK_FRST) |-> !vblank_o) else $error("act1"); // R5
  AST_TOPBLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o <= LW'(TOP_BLK_LAST) |-> vblank_o) else $error("topblk"); // R4
endmodule

// File: tb/fv625_gen_bench.sv
module fv625_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_start_i = 1'b0;
  logic       resync_i = 1'b0;
  logic [9:0] line_o;
  logic       field_o, vblank_o;

  int checks = 0, failures = 0;
  bit done = 0, running = 0;

  int    ref_line = 625;
  bit    ref_pend = 0;
  bit    after_rs = 0;
  int    rs_count = 0;
  string cause = "R1";

  always #5 clk_i = ~clk_i;

  fv625_gen u_fv625_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .resync_i(resync_i), .line_o(line_o), .field_o(field_o), .vblank_o(vblank_o)
  );

  function automatic bit exp_f(int l);
    return l >= 313;
  endfunction
  function automatic bit exp_v(int l);
    return (l <= 22) || (l >= 311 && l <= 335) || (l >= 624);
  endfunction
  function automatic string fv_tag(int l);
    if (l <= 22)  return "R4";
    if (l <= 310) return "R5";
    if (l <= 312) return "R6";
    if (l <= 335) return "R7";
    if (l <= 623) return "R8";
    return "R9";
  endfunction

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_line = 625; ref_pend = 0; after_rs = 0; rs_count = 0; cause = "R1";
    end else if (line_start_i) begin
      if (resync_i) begin
        ref_line = 1; cause = "R11"; after_rs = 1;
      end else if (ref_pend) begin
        ref_line = 1; cause = (rs_count > 1) ? "R12" : "R10"; after_rs = 1;
      end else begin
        cause = after_rs ? "R12" : (ref_line == 625 ? "R3" : "R2");
        ref_line = (ref_line == 625) ? 1 : ref_line + 1;
        after_rs = 0;
      end
      ref_pend = 0; rs_count = 0;
    end else if (resync_i) begin
      ref_pend = 1; rs_count++; cause = "R10";
    end else if (cause != "R1") begin
      cause = "R2";
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (running && rst_ni) begin
      check(cause, "line", int'(line_o), ref_line);
      check(fv_tag(ref_line), "field", int'(field_o), int'(exp_f(ref_line)));
      check(fv_tag(ref_line), "vblank", int'(vblank_o), int'(exp_v(ref_line)));
    end
  end

  task automatic cyc(bit ls, bit rs);
    @(negedge clk_i);
    line_start_i = ls;
    resync_i = rs;
  endtask

  task automatic lines(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0);
      for (int g = 0; g < gap; g++) cyc(0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "reset line", int'(line_o), 625);
    check("R1", "reset field", int'(field_o), 1);
    check("R1", "reset vblank", int'(vblank_o), 1);
    rst_ni = 1'b1;
    running = 1;
    cyc(0, 0); cyc(0, 0);
    lines(1300, 3);      // two frames and more, sparse
    lines(400, 0);       // back to back
    cyc(0, 0);
    cyc(0, 1);           // R10: lone resync, held
    cyc(0, 0); cyc(0, 0);
    lines(5, 2);
    lines(100, 1);
    cyc(1, 1);           // R11: coincident
    lines(10, 1);
    cyc(0, 1); cyc(0, 0); cyc(0, 1); cyc(0, 1);   // R12: repeated
    lines(3, 2);
    cyc(0, 0); cyc(0, 0);
    running = 0;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule